// File: doc/BRIEF.md
# Programmable Waveform Bus Master Engine

This block is a bus-master sequencer whose behaviour comes from a small table of waveform vectors. A host writes the table. The engine drives three control outputs and reads two ready inputs. Each vector sets the control output levels for one interface clock cycle. A vector can take one of two branch targets, depending on a condition it evaluates on the ready inputs. It can also pulse a FIFO-advance strobe and step a bus address. A vector marked as last closes one transaction.

A 32-bit transaction counter lets a waveform repeat on its own. The counter drops by one each time a transaction closes. The engine stops, with a one-cycle done pulse, after the transaction that takes the counter to zero. Any vector that wants a FIFO step stalls while the data FIFO cannot supply or accept data, and the engine resumes by itself when that condition clears. The data path is 8 or 16 bits wide, and the address step per access follows that width.

Top module: `wave_master`

## Requirements
- R1: After reset the outputs are: busy_o=0, done_o=0, fifo_adv_o=0, addr_o=0, count_o=0, and ctl_o at its idle value 3'b000.
- R2: A table write with tbl_we_i=1 stores tbl_wdata_i into entry tbl_addr_i. The vector layout is:
  - [2:0] control levels
  - [4:3] ready mode
  - [5] ready polarity
  - [6] branch flag
  - [9:7] target when true
  - [12:10] target when false
  - [13] FIFO advance
  - [14] address increment
  - [15] last vector
- R3: start_i while idle sets busy_o on the next edge and executes vector 0. start_i while busy has no effect.
- R4: While busy, ctl_o equals the control field of the current vector. The engine moves to a new vector every unstalled cycle, so ctl_o can change every cycle.
- R5: The ready condition compares each ready input with the polarity bit. The modes are:
  - 0: use rdy_i[0]
  - 1: use rdy_i[1]
  - 2: both inputs must match
  - 3: either input may match

  A branch vector moves to the true target if the condition holds and to the false target otherwise. A vector without branch moves to the next index.
- R6: fifo_adv_o is high, in the same cycle, exactly while a busy, unstalled vector has its FIFO-advance bit set.
- R7: addr_o is cleared at start. Each executed vector with the address bit set adds 1 to addr_o when wide_i=0 and 2 when wide_i=1.
- R8: A vector with the FIFO-advance bit stalls in two cases: dir_out_i=1 with fifo_empty_i=1, or dir_out_i=0 with fifo_full_i=1. While stalled, its index and address are held and there is no strobe. Execution resumes when the condition clears.
- R9: cnt_we_i loads count_o from cnt_wdata_i only while idle and is ignored while busy. count_o drops by one each time a last vector executes.
- R10: If a last vector executes with count_o=1, count_o becomes 0, busy_o falls and done_o is high for exactly one cycle. Otherwise execution restarts at vector 0.
- R11: A start with count_o=0 runs 2^32 transactions: after the first one, count_o reads 32'hFFFFFFFF and the engine stays busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_we_i | input | 1 | Vector table write enable |
| tbl_addr_i | input | 3 | Vector table write index |
| tbl_wdata_i | input | 16 | Vector to write |
| cnt_we_i | input | 1 | Transaction count load (idle only) |
| cnt_wdata_i | input | 32 | Transaction count value |
| start_i | input | 1 | Begin execution at vector 0 |
| rdy_i | input | 2 | Ready inputs |
| dir_out_i | input | 1 | 1: FIFO feeds the bus, 0: bus fills the FIFO |
| wide_i | input | 1 | 1: 16-bit data path, 0: 8-bit |
| fifo_empty_i | input | 1 | Data FIFO empty |
| fifo_full_i | input | 1 | Data FIFO full |
| ctl_o | output | 3 | Control outputs |
| fifo_adv_o | output | 1 | FIFO advance strobe |
| addr_o | output | 16 | Bus address |
| busy_o | output | 1 | Engine running |
| done_o | output | 1 | One-cycle completion pulse |
| count_o | output | 32 | Remaining transactions |

## Verification
The assertions check these behaviours on every cycle:
- a start from idle always lands on vector 0;
- a stalled vector holds its index and address;
- the strobe never fires against an empty or full FIFO;
- each address step is 0, 1 or 2;
- each counter decrement is exactly one;
- done is a single-cycle pulse seen only while idle.

Only the bench scenarios can show the rest: branch selection under each ready mode and polarity, the final address after whole multi-transaction runs in both widths, that start and count loads are ignored while busy, and the wrap from a zero count to the full 2^32 range.

// File: rtl/wave_pkg.sv
package wave_pkg;
  localparam int NVEC  = 8;
  localparam int IDX_W = $clog2(NVEC);
  localparam int CTL_W = 3;
  localparam int RDY_W = 2;

  typedef enum logic [1:0] {RDY_0, RDY_1, RDY_ALL, RDY_ANY} rdy_mode_e;

  typedef struct packed {
    logic             last;
    logic             addr_inc;
    logic             fifo_adv;
    logic [IDX_W-1:0] tgt_false;
    logic [IDX_W-1:0] tgt_true;
    logic             branch;
    logic             rdy_pol;
    rdy_mode_e        rdy_mode;
    logic [CTL_W-1:0] ctl;
  } vec_t;

  localparam int VEC_W = $bits(vec_t);
endpackage

// File: rtl/wave_vec_table.sv
module wave_vec_table
  import wave_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  vec_t             wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output vec_t             rdata_o
);
  vec_t mem_q [NVEC];

  for (genvar g = 0; g < NVEC; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               mem_q[g] <= '0;
      else if (we_i && waddr_i == IDX_W'(g))     mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/wave_txn_cnt.sv
module wave_txn_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] count_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign count_o = cnt_q;
  assign last_o  = (cnt_q == CNT_W'(1));

  // R9: each completed transaction removes exactly one from the count
  a_r9_dec_by_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i && !load_i |=> count_o == $past(count_o) - CNT_W'(1));
endmodule

// File: rtl/wave_seq.sv
module wave_seq
  import wave_pkg::*;
#(
  parameter int               ADDR_W   = 16,
  parameter logic [CTL_W-1:0] IDLE_CTL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  vec_t             vec_i,
  input  logic [RDY_W-1:0] rdy_i,
  input  logic             dir_out_i,
  input  logic             wide_i,
  input  logic             fifo_empty_i,
  input  logic             fifo_full_i,
  input  logic             last_txn_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [CTL_W-1:0] ctl_o,
  output logic             fifo_adv_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic             txn_done_o,
  output logic             busy_o,
  output logic             done_o
);
  logic             busy_q, done_q;
  logic [IDX_W-1:0] idx_q, nxt_idx;
  logic [ADDR_W-1:0] addr_q;
  logic [RDY_W-1:0] rdy_match;
  logic             cond, starve, step;

  assign rdy_match = ~(rdy_i ^ {RDY_W{vec_i.rdy_pol}});

  always_comb begin
    unique case (vec_i.rdy_mode)
      RDY_0:   cond = rdy_match[0];
      RDY_1:   cond = rdy_match[1];
      RDY_ALL: cond = &rdy_match;
      default: cond = |rdy_match;
    endcase
  end

  // starve on empty when sourcing the bus, on full when sinking it
  assign starve  = vec_i.fifo_adv & (dir_out_i ? fifo_empty_i : fifo_full_i);
  assign step    = busy_q & ~starve;
  assign nxt_idx = vec_i.branch ? (cond ? vec_i.tgt_true : vec_i.tgt_false)
                                : idx_q + IDX_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      addr_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          idx_q  <= '0;
          addr_q <= '0;
        end
      end else if (step) begin
        if (vec_i.addr_inc) addr_q <= addr_q + (wide_i ? ADDR_W'(2) : ADDR_W'(1));
        if (vec_i.last) begin
          idx_q <= '0;
          if (last_txn_i) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end else begin
          idx_q <= nxt_idx;
        end
      end
    end
  end

  assign idx_o      = idx_q;
  assign ctl_o      = busy_q ? vec_i.ctl : IDLE_CTL;
  assign fifo_adv_o = step & vec_i.fifo_adv;
  assign txn_done_o = step & vec_i.last;
  assign addr_o     = addr_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;

  a_r3_start_vec0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i |=> busy_o && idx_o == '0);
  a_r8_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && starve |=> $stable(idx_o) && $stable(addr_o) && busy_o);
  a_r7_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> addr_o == $past(addr_o) || addr_o == $past(addr_o) + ADDR_W'(1)
               || addr_o == $past(addr_o) + ADDR_W'(2));
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: rtl/wave_master.sv
module wave_master
  import wave_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tbl_we_i,
  input  logic [IDX_W-1:0]  tbl_addr_i,
  input  logic [VEC_W-1:0]  tbl_wdata_i,
  input  logic              cnt_we_i,
  input  logic [CNT_W-1:0]  cnt_wdata_i,
  input  logic              start_i,
  input  logic [RDY_W-1:0]  rdy_i,
  input  logic              dir_out_i,
  input  logic              wide_i,
  input  logic              fifo_empty_i,
  input  logic              fifo_full_i,
  output logic [CTL_W-1:0]  ctl_o,
  output logic              fifo_adv_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  count_o
);
  vec_t             cur_vec;
  logic [IDX_W-1:0] cur_idx;
  logic             txn_done, last_txn;

  wave_vec_table u_tbl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (tbl_we_i),
    .waddr_i (tbl_addr_i),
    .wdata_i (vec_t'(tbl_wdata_i)),
    .raddr_i (cur_idx),
    .rdata_o (cur_vec)
  );

  wave_txn_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_we_i & ~busy_o),
    .load_val_i (cnt_wdata_i),
    .dec_i      (txn_done),
    .count_o    (count_o),
    .last_o     (last_txn)
  );

  wave_seq #(.ADDR_W(ADDR_W), .IDLE_CTL('0)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .vec_i        (cur_vec),
    .rdy_i        (rdy_i),
    .dir_out_i    (dir_out_i),
    .wide_i       (wide_i),
    .fifo_empty_i (fifo_empty_i),
    .fifo_full_i  (fifo_full_i),
    .last_txn_i   (last_txn),
    .idx_o        (cur_idx),
    .ctl_o        (ctl_o),
    .fifo_adv_o   (fifo_adv_o),
    .addr_o       (addr_o),
    .txn_done_o   (txn_done),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  // R6, R8: no strobe against a FIFO that cannot serve it
  a_r8_no_adv_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_adv_o && dir_out_i |-> !fifo_empty_i);
  a_r8_no_adv_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_adv_o && !dir_out_i |-> !fifo_full_i);
  a_r9_idle_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) && !$past(txn_done) |-> $stable(count_o));
endmodule

// File: tb/wave_master_tb.sv
module wave_master_tb;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        tbl_we_i = 0, cnt_we_i = 0, start_i = 0;
  logic [2:0]  tbl_addr_i = 0;
  logic [15:0] tbl_wdata_i = 0;
  logic [31:0] cnt_wdata_i = 0;
  logic [1:0]  rdy_i = 0;
  logic        dir_out_i = 1, wide_i = 0, fifo_empty_i = 0, fifo_full_i = 0;
  logic [2:0]  ctl_o;
  logic        fifo_adv_o, busy_o, done_o;
  logic [15:0] addr_o;
  logic [31:0] count_o;

  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  wave_master u_dut (.*);

  // behavioural reference model
  logic [15:0] m_tbl [8];
  logic        m_busy, m_done;
  logic [2:0]  m_idx;
  logic [15:0] m_addr;
  logic [31:0] m_cnt;
  logic [15:0] cur;
  logic        m_cond, m_go;
  logic [1:0]  hit;

  always_comb begin
    cur    = m_tbl[m_idx];
    hit[0] = (rdy_i[0] == cur[5]);
    hit[1] = (rdy_i[1] == cur[5]);
    case (cur[4:3])
      2'd0: m_cond = hit[0];
      2'd1: m_cond = hit[1];
      2'd2: m_cond = hit[0] && hit[1];
      default: m_cond = hit[0] || hit[1];
    endcase
    m_go = m_busy && !(cur[13] && (dir_out_i ? fifo_empty_i : fifo_full_i));
  end

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 8; i++) m_tbl[i] <= 16'h0;
      m_busy <= 0; m_done <= 0; m_idx <= 0; m_addr <= 0; m_cnt <= 0;
    end else begin
      if (tbl_we_i) m_tbl[tbl_addr_i] <= tbl_wdata_i;
      m_done <= 0;
      if (!m_busy) begin
        if (cnt_we_i) m_cnt <= cnt_wdata_i;
        if (start_i) begin m_busy <= 1; m_idx <= 0; m_addr <= 0; end
      end else if (m_go) begin
        if (cur[14]) m_addr <= m_addr + (wide_i ? 16'd2 : 16'd1);
        if (cur[15]) begin
          m_cnt <= m_cnt - 1;
          m_idx <= 0;
          if (m_cnt == 1) begin m_busy <= 0; m_done <= 1; end
        end else if (cur[6]) m_idx <= m_cond ? cur[9:7] : cur[12:10];
        else m_idx <= m_idx + 3'd1;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) if (rst_ni) begin
    chk("R4 ctl", 32'(ctl_o), 32'(m_busy ? cur[2:0] : 3'b000));
    chk("R6 fifo_adv", 32'(fifo_adv_o), 32'(m_go && cur[13]));
    chk("R7 addr", 32'(addr_o), 32'(m_addr));
    chk("R3 busy", 32'(busy_o), 32'(m_busy));
    chk("R10 done", 32'(done_o), 32'(m_done));
    chk("R9 count", count_o, m_cnt);
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic tick(); @(posedge clk_i); #1; endtask

  function automatic logic [15:0] mk(logic [2:0] ctl, logic [1:0] mode, logic pol,
      logic br, logic [2:0] tt, logic [2:0] tf, logic adv, logic ai, logic last);
    return {last, ai, adv, tf, tt, br, pol, mode, ctl};
  endfunction

  task automatic wr_vec(int idx, logic [15:0] v);
    tbl_we_i = 1; tbl_addr_i = 3'(idx); tbl_wdata_i = v; tick(); tbl_we_i = 0;
  endtask

  task automatic go(logic [31:0] n);
    cnt_we_i = 1; cnt_wdata_i = n; start_i = 1; tick();
    cnt_we_i = 0; start_i = 0;
  endtask

  task automatic wait_done(string req, output int seen);
    seen = 0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk_i);
      if (done_o) begin seen = 1; break; end
    end
    chk(req, 32'(seen), 32'd1);
  endtask

  int seen;

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 busy", 32'(busy_o), 0);
    chk("R1 done", 32'(done_o), 0);
    chk("R1 ctl", 32'(ctl_o), 0);
    chk("R1 addr", 32'(addr_o), 0);
    chk("R1 count", count_o, 0);
    chk("R1 adv", 32'(fifo_adv_o), 0);

    // R2 table load: v1 waits for rdy0 high
    wr_vec(0, mk(3'd1, 2'd0, 0, 0, 0, 0, 1, 1, 0));
    wr_vec(1, mk(3'd2, 2'd0, 1, 1, 3'd2, 3'd1, 0, 0, 0));
    wr_vec(2, mk(3'd4, 2'd0, 0, 0, 0, 0, 0, 1, 1));
    go(3);
    repeat (5) tick();
    @(negedge clk_i);
    chk("R5 wait on rdy0", 32'(ctl_o), 32'd2);
    tick(); rdy_i = 2'b01;
    wait_done("R10 done after 3 txns", seen);
    chk("R7 byte addr", 32'(addr_o), 32'd6);
    chk("R9 count zero", count_o, 0);
    @(negedge clk_i);
    chk("R10 single pulse", 32'(done_o), 0);

    // R8 outbound stall, wide path, start/load while busy ignored
    tick(); wide_i = 1; fifo_empty_i = 1;
    go(2);
    repeat (3) tick();
    start_i = 1; cnt_we_i = 1; cnt_wdata_i = 32'd99; tick();
    start_i = 0; cnt_we_i = 0;
    @(negedge clk_i);
    chk("R8 addr held", 32'(addr_o), 0);
    chk("R8 no strobe", 32'(fifo_adv_o), 0);
    chk("R9 load ignored busy", count_o, 32'd2);
    tick(); fifo_empty_i = 0;
    wait_done("R8 resumed", seen);
    chk("R7 word addr", 32'(addr_o), 32'd8);

    // R8 inbound stall: empty irrelevant, full stalls
    tick(); dir_out_i = 0; fifo_full_i = 1; fifo_empty_i = 1;
    go(1);
    repeat (3) tick();
    @(negedge clk_i);
    chk("R8 inbound held", 32'(addr_o), 0);
    tick(); fifo_full_i = 0;
    wait_done("R8 inbound resumed", seen);
    chk("R7 inbound addr", 32'(addr_o), 32'd4);

    // R5 mode 2 (both low)
    tick(); fifo_empty_i = 0; wide_i = 0; rdy_i = 2'b10;
    wr_vec(1, mk(3'd2, 2'd2, 0, 1, 3'd2, 3'd1, 0, 0, 0));
    go(1);
    repeat (4) tick();
    @(negedge clk_i);
    chk("R5 all-mode wait", 32'(ctl_o), 32'd2);
    tick(); rdy_i = 2'b00;
    wait_done("R5 all-mode pass", seen);

    // R5 mode 3 (either high), branch to 2 directly
    tick(); rdy_i = 2'b00;
    wr_vec(1, mk(3'd6, 2'd3, 1, 1, 3'd2, 3'd1, 0, 0, 0));
    go(1);
    repeat (4) tick();
    @(negedge clk_i);
    chk("R5 any-mode wait", 32'(ctl_o), 32'd6);
    tick(); rdy_i = 2'b10;
    wait_done("R5 any-mode pass", seen);

    // R11 zero count wraps to full range
    tick(); rdy_i = 2'b11;
    go(0);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk_i);
      if (count_o != 0) break;
    end
    chk("R11 wrap count", count_o, 32'hFFFF_FFFF);
    chk("R11 still busy", 32'(busy_o), 1);
    tick(); rst_ni = 0; tick(); rst_ni = 1;
    @(negedge clk_i);
    chk("R1 reset idle", 32'(busy_o), 0);
    summary();
  end
endmodule